// File: doc/BRIEF.md
# Multiplexed Byte-Bus Master with Acknowledge Handshake

This block carries out single-byte read and write transactions on a narrow parallel bus. On that bus one 8-bit data path carries both the address and the data. A 16-bit address goes out as two byte phases. Each phase is marked by its own address-latch strobe. The data phase follows. The master then asserts one of two active-low chip selects, followed by an active-low read or write strobe. It then waits for the target to pull an active-low acknowledge line. If no acknowledge arrives, the wait ends after a bounded number of cycles.

A command is presented as a request with a 16-bit address, a write byte, a direction flag and a target select. The master takes a request only while it is idle. When the bus is back in its idle state it raises `done` for one cycle. The same cycle shows the read byte and a flag that tells whether the acknowledge wait ran out. The acknowledge pin is asynchronous to the master. It passes through a two-flop synchronizer before the sequencer looks at it. Every setup phase lasts a parameterized number of cycles, so slow targets can be served.

Top module: `mbus_master`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `cs_n` is 2'b11, `rd_n` and `wr_n` are 1, `ale_lo`, `ale_hi`, `bus_oe`, `busy`, `done` and `timeout_err` are 0.
- R2: In the cycle where `done` is 1, `cs_n` is 2'b11, `rd_n` and `wr_n` are 1, `busy` is 0 and `bus_oe` is 0.
- R3: After a request is accepted, `ale_lo` is 1 for exactly SETUP_CYC cycles with `bus_oe`=1 and `bus_dout` equal to address bits 7:0. Throughout those cycles `cs_n` is 2'b11 and both strobes are high.
- R4: After the low-address phase and its release, `ale_hi` is 1 for exactly SETUP_CYC cycles with `bus_oe`=1 and `bus_dout` equal to address bits 15:8. It is never asserted before the low-address phase of the same transaction.
- R5: On a write, `bus_oe` is 1 and `bus_dout` equals the write byte in every cycle where `wr_n` is 0. On a read, `bus_oe` is 0 in every cycle where `rd_n` is 0.
- R6: The selected chip select is low, with both strobes still high, for exactly SETUP_CYC cycles before the strobe falls. `rd_n` falls for reads (`req_write`=0) and `wr_n` falls for writes (`req_write`=1). No strobe is low while both chip selects are high.
- R7: `req_target`=0 drives only `cs_n[0]` low and `req_target`=1 drives only `cs_n[1]` low. Both are never low together.
- R8: `ack_n` passes through two flops before use. If it is driven low D cycles into the strobe, the strobe stays low for D+2 cycles and `timeout_err` is 0 with `done`.
- R9: If `ack_n` stays high, the strobe stays low for exactly TIMEOUT_CYC cycles. The bus then returns to idle and `done` is raised with `timeout_err`=1. `timeout_err` holds until the next request is accepted.
- R10: `done` is 1 for exactly one cycle per transaction. For a read, `rd_data` then holds the `bus_din` value that was present in the last strobe cycle.
- R11: A `req_valid` raised while `busy` is 1 is ignored. No address phase starts for it, and `busy` stays 0 after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_target | input | 1 | Selects chip select 0 or 1 |
| req_addr | input | 16 | Transaction address |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte captured on a read |
| timeout_err | output | 1 | Acknowledge wait expired |
| bus_dout | output | 8 | Data/address byte driven to the bus |
| bus_oe | output | 1 | Enables the data-line drivers |
| bus_din | input | 8 | Data lines sampled from the bus |
| cs_n | output | 2 | Active-low chip selects |
| ale_lo | output | 1 | Low-address latch strobe |
| ale_hi | output | 1 | High-address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ack_n | input | 1 | Active-low acknowledge from the target |

## Verification
The bench builds the block with SETUP_CYC=3 and TIMEOUT_CYC=24. With three cycles per phase, the exact length of each address, data and select phase can be counted, and an off-by-one in the phase timer shows up. A 24-cycle timeout puts the expiry path within a few dozen cycles of a transaction, so a silent target can be tested directly. The same setting leaves room for acknowledge delays of 1, 5 and 12 cycles, and each of those gives an exact strobe length through the synchronizer.

// File: rtl/mbus_pkg.sv
// Shared types for the multiplexed byte-bus master.
package mbus_pkg;

    // Sequencer phases, in bus order.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ALO     = 3'd1,
        ST_ALO_REL = 3'd2,
        ST_AHI     = 3'd3,
        ST_AHI_REL = 3'd4,
        ST_DATA    = 3'd5,
        ST_SEL     = 3'd6,
        ST_STRB    = 3'd7
    } mbus_state_t;

endpackage

// File: rtl/mbus_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes: STAGES >= 2; the reset value is the input's inactive level.
module mbus_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/mbus_timer.sv
// Phase-length counter: cleared on a phase change, saturates at all ones.
// Assumes: clr is raised on the edge where the sequencer enters a new phase.
module mbus_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [WIDTH-1:0] count
);
    // Count cycles spent in the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)     count <= '0;
        else if (count != '1)  count <= count + 1'b1;
    end
endmodule

// File: rtl/mbus_master.sv
// Master for single-byte transfers on a multiplexed 8-bit bus.
// Sends a 16-bit address as two latch-strobed byte phases, then a data
// phase, a chip-select phase and a strobe phase that ends on a
// synchronized active-low acknowledge or a cycle-count timeout.
// Assumes: SETUP_CYC >= 1, TIMEOUT_CYC >= 2, ack_n is asynchronous.
module mbus_master
    import mbus_pkg::*;
#(
    parameter int SETUP_CYC   = 2,
    parameter int TIMEOUT_CYC = 200000,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_target,
    input  logic [15:0] req_addr,
    input  logic [7:0]  req_wdata,
    output logic        busy,
    output logic        done,
    output logic [7:0]  rd_data,
    output logic        timeout_err,
    output logic [7:0]  bus_dout,
    output logic        bus_oe,
    input  logic [7:0]  bus_din,
    output logic [1:0]  cs_n,
    output logic        ale_lo,
    output logic        ale_hi,
    output logic        rd_n,
    output logic        wr_n,
    input  logic        ack_n
);
    localparam int MAX_CYC = (SETUP_CYC > TIMEOUT_CYC) ? SETUP_CYC : TIMEOUT_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] TMO_LAST   = CW'(TIMEOUT_CYC - 1);

    mbus_state_t state_q, state_d;
    logic [CW-1:0] cnt;
    logic          ack_n_s;
    logic          phase_end, tmo_hit, strb_exit;
    logic [15:0]   addr_q;
    logic [7:0]    wdata_q, rdata_q;
    logic          write_q, target_q, done_q, tmo_q;

    mbus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) ack_sync_i (
        .clk(clk), .rst_n(rst_n), .din(ack_n), .dout(ack_n_s)
    );

    mbus_timer #(.WIDTH(CW)) phase_timer_i (
        .clk(clk), .rst_n(rst_n), .clr(state_d != state_q), .count(cnt)
    );

    assign phase_end = (cnt == SETUP_LAST);
    assign tmo_hit   = (cnt == TMO_LAST);
    assign strb_exit = (state_q == ST_STRB) && (!ack_n_s || tmo_hit);

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_ALO;
            ST_ALO:     if (phase_end) state_d = ST_ALO_REL;
            ST_ALO_REL: if (phase_end) state_d = ST_AHI;
            ST_AHI:     if (phase_end) state_d = ST_AHI_REL;
            ST_AHI_REL: if (phase_end) state_d = ST_DATA;
            ST_DATA:    if (phase_end) state_d = ST_SEL;
            ST_SEL:     if (phase_end) state_d = ST_STRB;
            ST_STRB:    if (strb_exit) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            write_q  <= 1'b0;
            target_q <= 1'b0;
        end else if (state_q == ST_IDLE && req_valid) begin
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
            write_q  <= req_write;
            target_q <= req_target;
        end
    end

    // Completion pulse, timeout flag and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            tmo_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= strb_exit;
            if (strb_exit) begin
                tmo_q <= ack_n_s;
                if (!write_q) rdata_q <= bus_din;
            end else if (state_q == ST_IDLE && req_valid) begin
                tmo_q <= 1'b0;
            end
        end
    end

    // Bus pin decode from the phase register.
    always_comb begin
        bus_dout = 8'h00;
        bus_oe   = 1'b0;
        unique case (state_q)
            ST_ALO, ST_ALO_REL: begin bus_dout = addr_q[7:0];  bus_oe = 1'b1;    end
            ST_AHI, ST_AHI_REL: begin bus_dout = addr_q[15:8]; bus_oe = 1'b1;    end
            ST_DATA, ST_SEL, ST_STRB: begin bus_dout = wdata_q; bus_oe = write_q; end
            default: ;
        endcase
    end

    assign ale_lo      = (state_q == ST_ALO);
    assign ale_hi      = (state_q == ST_AHI);
    assign cs_n        = (state_q == ST_SEL || state_q == ST_STRB)
                         ? (target_q ? 2'b01 : 2'b10) : 2'b11;
    assign rd_n        = !(state_q == ST_STRB && !write_q);
    assign wr_n        = !(state_q == ST_STRB &&  write_q);
    assign busy        = (state_q != ST_IDLE);
    assign done        = done_q;
    assign timeout_err = tmo_q;
    assign rd_data     = rdata_q;

    AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);                                          // R7
    AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> (cs_n != 2'b11));                            // R6
    AST_ALE_CTRL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_lo || ale_hi) |-> (cs_n == 2'b11 && rd_n && wr_n));          // R3
    AST_READ_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !bus_oe);                                               // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                  // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && cs_n == 2'b11 && rd_n && wr_n));               // R2
    AST_ACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STRB && !ack_n_s) |=> (done && !timeout_err));     // R8
    AST_TMO_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> done);                                     // R9
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ale_lo && $past(busy)) |-> $stable(addr_q));            // R11
endmodule

// File: tb/mbus_master_tb.sv
`timescale 1ns/1ps
module mbus_master_tb_top;
    localparam int SETUP = 3;
    localparam int TMO   = 24;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, req_target = 0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0, bus_din = '0;
    logic ack_n = 1'b1;
    logic busy, done, timeout_err, bus_oe, ale_lo, ale_hi, rd_n, wr_n;
    logic [7:0] rd_data, bus_dout;
    logic [1:0] cs_n;

    int n_chk = 0, n_fail = 0;
    int ack_delay = 0;
    logic [7:0] rd_val = '0;

    // monitor state
    logic        mon_on = 0;
    logic [15:0] m_addr;
    logic [7:0]  m_wdata;
    logic        m_write, m_target;
    logic [15:0] m_ghost;
    int c_alo, c_ahi, c_sel, c_strb, c_done, c_ghost;
    int bad_data, bad_cs, bad_order;

    always #2.5 clk = ~clk;

    mbus_master #(.SETUP_CYC(SETUP), .TIMEOUT_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_target(req_target), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .timeout_err(timeout_err),
        .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din), .cs_n(cs_n),
        .ale_lo(ale_lo), .ale_hi(ale_hi), .rd_n(rd_n), .wr_n(wr_n), .ack_n(ack_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Target model: acknowledges ack_delay cycles into a strobe, returns rd_val.
    int k = 0;
    always @(negedge clk) begin
        if (rst_n && (!rd_n || !wr_n)) begin
            k = k + 1;
            if (ack_delay != 0 && k >= ack_delay) ack_n <= 1'b0;
            bus_din <= rd_val;
        end else begin
            k = 0;
            ack_n   <= 1'b1;
            bus_din <= 8'h00;
        end
    end

    // Bus monitor: per-transaction phase counts and rule violations.
    always @(negedge clk) begin
        if (mon_on) begin
            if (ale_lo && bus_oe && bus_dout == m_addr[7:0]) c_alo++;
            if (ale_lo && bus_dout == m_ghost[7:0] && m_ghost[7:0] != m_addr[7:0]) c_ghost++;
            if (ale_hi && bus_oe && bus_dout == m_addr[15:8]) c_ahi++;
            if (ale_hi && c_alo == 0) bad_order++;
            if (cs_n == (m_target ? 2'b01 : 2'b10) && rd_n && wr_n) c_sel++;
            if (cs_n == (m_target ? 2'b10 : 2'b01) || cs_n == 2'b00) bad_cs++;
            if (m_write ? !wr_n : !rd_n) c_strb++;
            if (m_write ? !rd_n : !wr_n) bad_cs++;
            if (!wr_n && (!bus_oe || bus_dout != m_wdata)) bad_data++;
            if (!rd_n && bus_oe) bad_data++;
            if (done) c_done++;
        end
    end

    task automatic do_xfer(input logic wr, input logic tgt, input logic [15:0] addr,
                           input logic [7:0] wd, input int dly, input logic [7:0] rv,
                           input logic ghost);
        int guard;
        c_alo = 0; c_ahi = 0; c_sel = 0; c_strb = 0; c_done = 0; c_ghost = 0;
        bad_data = 0; bad_cs = 0; bad_order = 0;
        m_addr = addr; m_wdata = wd; m_write = wr; m_target = tgt;
        m_ghost = ~addr;
        ack_delay = dly; rd_val = rv;
        mon_on = 1;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_target = tgt; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        if (ghost) begin
            repeat (4) @(negedge clk);
            req_valid = 1; req_addr = ~addr; req_write = ~wr;
            repeat (3) @(negedge clk);
            req_valid = 0;
        end
        guard = 0;
        while (!done && guard < 200) begin @(negedge clk); guard++; end
        // R2: idle bus in the done cycle
        chk("R2 cs_n idle at done", int'(cs_n), 3);
        chk("R2 strobes high at done", int'({rd_n, wr_n}), 3);
        chk("R2 busy low at done", int'(busy), 0);
        chk("R2 oe off at done", int'(bus_oe), 0);
        if (dly == 0) chk("R9 timeout_err set", int'(timeout_err), 1);
        else          chk("R8 timeout_err clear", int'(timeout_err), 0);
        if (!wr) chk("R10 rd_data", int'(rd_data), int'(rv));
        repeat (5) @(negedge clk);
        mon_on = 0;
        chk("R3 ale_lo cycles", c_alo, SETUP);
        chk("R4 ale_hi cycles", c_ahi, SETUP);
        chk("R4 hi after lo", bad_order, 0);
        chk("R6 select-before-strobe cycles", c_sel, SETUP);
        chk("R7 wrong or double cs / wrong strobe", bad_cs, 0);
        chk("R5 data lines during strobe", bad_data, 0);
        if (dly == 0) chk("R9 strobe length", c_strb, TMO);
        else          chk("R8 strobe length", c_strb, dly + 2);
        chk("R10 done pulses", c_done, 1);
        if (dly == 0) chk("R9 timeout_err held", int'(timeout_err), 1);
        if (ghost) begin
            chk("R11 no phase for ignored request", c_ghost, 0);
            chk("R11 idle after done", int'(busy), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cs_n", int'(cs_n), 3);
        chk("R1 strobes", int'({rd_n, wr_n}), 3);
        chk("R1 ale/oe", int'({ale_lo, ale_hi, bus_oe}), 0);
        chk("R1 busy/done/tmo", int'({busy, done, timeout_err}), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 first cycle idle", int'({busy, done, timeout_err}), 0);

        do_xfer(1'b1, 1'b0, 16'hA55A, 8'h3C, 1,  8'h00, 1'b0); // write, cs0, fast ack
        do_xfer(1'b0, 1'b1, 16'h1234, 8'h00, 5,  8'hC7, 1'b0); // read, cs1
        do_xfer(1'b0, 1'b0, 16'hFF00, 8'h00, 0,  8'h5E, 1'b0); // read timeout
        do_xfer(1'b1, 1'b1, 16'h00FF, 8'h81, 12, 8'h00, 1'b1); // write, late ack, ignored req; clears flag
        do_xfer(1'b1, 1'b0, 16'h8001, 8'hE4, 0,  8'h00, 1'b0); // write timeout
        do_xfer(1'b0, 1'b1, 16'h7E81, 8'h00, 3,  8'h96, 1'b1); // read with ignored req

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule